// File: doc/BRIEF.md
# Interrupt and Stack PC Sequencer

This block holds the program counter and the stack pointer of a small pipelined processor and runs the two control sequences that move the PC through memory: interrupt entry and return from interrupt. In normal operation the PC advances by one on each fetch, or it takes a branch target. When an interrupt request arrives, the block stops admitting new instructions and waits for the pipeline to report that it is empty. It then saves the address of the next instruction on a stack in data memory and loads a fresh PC from a two-word vector.

A return request takes the saved PC off the stack, so execution continues after the interrupted instruction. Memory is 16-bit word addressable with a 12-bit address. The data-memory port is 32 bits wide, so one access carries a whole PC. A 32-bit access at address A holds the low half at A and the high half at A+1. The stack grows downward from the highest address.

Top module: `irq_pc_sequencer`

## Requirements
- R1: After reset the PC equals RESET_PC (default 0), the stack pointer is 0xFFF, and busy, hold and the memory request are all low.
- R2: While hold is low, pc_inc_i adds one to the PC at each clock edge. branch_i loads branch_tgt_i and takes precedence over pc_inc_i.
- R3: A cycle with irq_i high raises hold and busy from the next cycle on. pc_inc_i has no effect while hold is high. Busy always implies hold.
- R4: Once an entry has started, no memory access is made until drained_i has been seen high. The push is issued in the cycle after the edge where drained_i was sampled high. A branch_i seen before then still updates the PC that is pushed.
- R5: The push is a single write (mem_req_o=1, mem_we_o=1) at address SP-1 carrying the current PC. The stack pointer then falls by 2.
- R6: In the cycle after the push, the block reads address 2 (mem_we_o=0). The word returned one cycle later, {word at 3, word at 2}, becomes the PC. Busy stays high through that load cycle and drops one cycle later, unless another request is pending.
- R7: When rti_i is high in an idle cycle, the block reads at SP+1 and the stack pointer rises by 2. The PC takes the returned 32-bit value two cycles after the request.
- R8: An irq_i that arrives during entry or return is held pending and is serviced once the current sequence ends. If a return request and a pending interrupt meet in an idle cycle, the return goes first.
- R9: rti_i has no effect outside the idle state: it starts no memory access and leaves the stack pointer unchanged.
- R10: Stack pointer arithmetic wraps modulo 4096. The stack pointer changes only in cycles that carry a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request, one request per high cycle |
| drained_i | input | 1 | Pipeline reports that all in-flight instructions have completed |
| rti_i | input | 1 | Return-from-interrupt request |
| pc_inc_i | input | 1 | Advance the PC by one word |
| branch_i | input | 1 | Load the branch target into the PC |
| branch_tgt_i | input | PC_W | Branch target address |
| pc_o | output | PC_W | Current program counter |
| sp_o | output | ADDR_W | Current stack pointer |
| busy_o | output | 1 | Interrupt entry pending or in progress |
| hold_o | output | 1 | Fetch must admit no new instructions |
| mem_req_o | output | 1 | Data-memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Word address of the low half |
| mem_wdata_o | output | PC_W | Write data (PC) |
| mem_rdata_i | input | PC_W | Read data, valid the cycle after a read request |

## Verification
Each result has a fixed latency from its stimulus. Hold and busy appear one edge after irq_i. The push appears in the cycle after drained_i is sampled, and the vector read follows one cycle later. The new PC is visible two cycles after the vector read is issued. On a return, the read appears one cycle after rti_i, the stack pointer moves one cycle later, and the restored PC is visible three cycles after the request. The bench drives inputs on the falling edge and advances one full cycle per step. It compares each output exactly at the step where that result is due, using a PC, stack pointer and stack shadow that it keeps arithmetically on its own. It sweeps drain delays and nesting depths, and repeats the sequences with requests that overlap one another.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_PUSH  = 3'd2,
        ST_VREQ  = 3'd3,
        ST_VLOAD = 3'd4,
        ST_POP   = 3'd5,
        ST_PLOAD = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        MOP_NONE = 2'd0,
        MOP_PUSH = 2'd1,
        MOP_VEC  = 2'd2,
        MOP_POP  = 2'd3
    } mem_op_e;

    // States that belong to interrupt entry (busy window)
    function automatic logic in_entry(input seq_state_e s);
        return (s == ST_DRAIN) || (s == ST_PUSH) || (s == ST_VREQ) || (s == ST_VLOAD);
    endfunction

    // In-flight instructions may still redirect the PC in these states
    function automatic logic branch_window(input seq_state_e s);
        return (s == ST_IDLE) || (s == ST_DRAIN);
    endfunction

    function automatic mem_op_e op_of(input seq_state_e s);
        case (s)
            ST_PUSH: return MOP_PUSH;
            ST_VREQ: return MOP_VEC;
            ST_POP:  return MOP_POP;
            default: return MOP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/isq_ctrl.sv
`timescale 1ns/1ps
module isq_ctrl
    import isq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_i,
    input  logic       drained_i,
    input  logic       rti_i,
    output seq_state_e state_o,
    output mem_op_e    op_o,
    output logic       busy_o,
    output logic       hold_o,
    output logic       branch_ok_o,
    output logic       pc_load_o
);

    seq_state_e st_q, st_d;
    logic       pend_q, pend_d;

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q | irq_i;
        case (st_q)
            ST_IDLE: begin
                if (rti_i) begin
                    st_d = ST_POP;
                end else if (pend_q) begin
                    st_d   = ST_DRAIN;
                    pend_d = irq_i;
                end
            end
            ST_DRAIN: if (drained_i) st_d = ST_PUSH;
            ST_PUSH:  st_d = ST_VREQ;
            ST_VREQ:  st_d = ST_VLOAD;
            ST_VLOAD: st_d = ST_IDLE;
            ST_POP:   st_d = ST_PLOAD;
            ST_PLOAD: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    assign state_o     = st_q;
    assign op_o        = op_of(st_q);
    assign busy_o      = pend_q | in_entry(st_q);
    assign hold_o      = pend_q | (st_q != ST_IDLE);
    assign branch_ok_o = branch_window(st_q);
    assign pc_load_o   = (st_q == ST_VLOAD) || (st_q == ST_PLOAD);

endmodule

// File: rtl/isq_sp_unit.sv
`timescale 1ns/1ps
module isq_sp_unit
    import isq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_op_e           op_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] below_o,
    output logic [ADDR_W-1:0] above_o
);

    localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(2);

    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_TOP;
        end else begin
            case (op_i)
                MOP_PUSH: sp_q <= sp_q - STEP;
                MOP_POP:  sp_q <= sp_q + STEP;
                default:  sp_q <= sp_q;
            endcase
        end
    end

    assign sp_o    = sp_q;
    assign below_o = sp_q - ADDR_W'(1);
    assign above_o = sp_q + ADDR_W'(1);

endmodule

// File: rtl/isq_pc_unit.sv
`timescale 1ns/1ps
module isq_pc_unit #(
    parameter int          PC_W     = 32,
    parameter int unsigned RESET_PC = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [PC_W-1:0] load_val_i,
    input  logic            branch_i,
    input  logic [PC_W-1:0] branch_tgt_i,
    input  logic            inc_i,
    output logic [PC_W-1:0] pc_o
);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= PC_W'(RESET_PC);
        end else if (load_i) begin
            pc_q <= load_val_i;
        end else if (branch_i) begin
            pc_q <= branch_tgt_i;
        end else if (inc_i) begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/irq_pc_sequencer.sv
`timescale 1ns/1ps
module irq_pc_sequencer
    import isq_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter int          ADDR_W   = 12,
    parameter int unsigned VEC_ADDR = 2,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_i,
    input  logic              drained_i,
    input  logic              rti_i,
    input  logic              pc_inc_i,
    input  logic              branch_i,
    input  logic [PC_W-1:0]   branch_tgt_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              busy_o,
    output logic              hold_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [PC_W-1:0]   mem_wdata_o,
    input  logic [PC_W-1:0]   mem_rdata_i
);

    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

    seq_state_e        state;
    mem_op_e           op;
    logic              branch_ok, pc_load;
    logic [ADDR_W-1:0] sp_below, sp_above;

    isq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .irq_i       (irq_i),
        .drained_i   (drained_i),
        .rti_i       (rti_i),
        .state_o     (state),
        .op_o        (op),
        .busy_o      (busy_o),
        .hold_o      (hold_o),
        .branch_ok_o (branch_ok),
        .pc_load_o   (pc_load)
    );

    isq_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .sp_o    (sp_o),
        .below_o (sp_below),
        .above_o (sp_above)
    );

    isq_pc_unit #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
        .clk          (clk),
        .rst          (rst),
        .load_i       (pc_load),
        .load_val_i   (mem_rdata_i),
        .branch_i     (branch_i & branch_ok),
        .branch_tgt_i (branch_tgt_i),
        .inc_i        (pc_inc_i & ~hold_o),
        .pc_o         (pc_o)
    );

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (op)
            MOP_PUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_below;
                mem_wdata_o = pc_o;
            end
            MOP_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = VEC;
            end
            MOP_POP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_above;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_pc_sequencer_chk.sv
`timescale 1ns/1ps
module irq_pc_sequencer_chk #(
    parameter int          PC_W     = 32,
    parameter int          ADDR_W   = 12,
    parameter int unsigned VEC_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              drained_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic              busy_o,
    input logic              hold_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [PC_W-1:0]   mem_wdata_o
);

    // R3
    busy_implies_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> hold_o);

    // R4
    push_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> $past(drained_i));

    // R5
    push_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> (mem_addr_o == sp_o - ADDR_W'(1)) && (mem_wdata_o == pc_o));

    // R5
    push_sp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |=> (sp_o == $past(sp_o) - ADDR_W'(2)));

    // R6
    vector_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |=> (mem_req_o && !mem_we_o && mem_addr_o == ADDR_W'(VEC_ADDR)));

    // R10
    sp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_req_o |=> $stable(sp_o));

endmodule

bind irq_pc_sequencer irq_pc_sequencer_chk #(
    .PC_W     (PC_W),
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .drained_i   (drained_i),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .busy_o      (busy_o),
    .hold_o      (hold_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/irq_pc_sequencer_bench.sv
`timescale 1ns/1ps
module irq_pc_sequencer_bench;

    localparam int PC_W   = 32;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              irq = 1'b0, drained = 1'b0, rti = 1'b0, pc_inc = 1'b0, branch = 1'b0;
    logic [PC_W-1:0]   tgt = '0;
    logic [PC_W-1:0]   pc;
    logic [ADDR_W-1:0] sp;
    logic              busy, hold, mreq, mwe;
    logic [ADDR_W-1:0] maddr;
    logic [PC_W-1:0]   mwdata;
    logic [PC_W-1:0]   mrdata = '0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_pc_sequencer u_irq_pc_sequencer (
        .clk          (clk),
        .rst          (rst),
        .irq_i        (irq),
        .drained_i    (drained),
        .rti_i        (rti),
        .pc_inc_i     (pc_inc),
        .branch_i     (branch),
        .branch_tgt_i (tgt),
        .pc_o         (pc),
        .sp_o         (sp),
        .busy_o       (busy),
        .hold_o       (hold),
        .mem_req_o    (mreq),
        .mem_we_o     (mwe),
        .mem_addr_o   (maddr),
        .mem_wdata_o  (mwdata),
        .mem_rdata_i  (mrdata)
    );

    function automatic logic [15:0] initv(input int i);
        return 16'(i) ^ 16'h5A00;
    endfunction

    localparam logic [31:0] VEC = {16'h5A03, 16'h5A02};

    // data memory model: 16-bit words, 32-bit access, read data one cycle later
    logic [15:0] mem [DEPTH];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= initv(i);
        end else if (mreq && mwe) begin
            mem[maddr]         <= mwdata[15:0];
            mem[maddr + 12'd1] <= mwdata[31:16];
        end else if (mreq) begin
            mrdata <= {mem[maddr + 12'd1], mem[maddr]};
        end
    end

    logic [31:0]       exp_pc = '0;
    logic [ADDR_W-1:0] exp_sp = 12'hFFF;
    logic [31:0]       shadow [16];
    int                depth = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        pc_inc = 1'b1;
        for (int i = 0; i < n; i++) begin
            cyc();
            exp_pc = exp_pc + 1;
            check("R2 increment", pc, exp_pc);
        end
        pc_inc = 1'b0;
    endtask

    task automatic enter_irq(input int dl, input bit pulse, input bit extra,
                             input bit rti_in_drain, input bit br);
        pc_inc = 1'b1;
        if (pulse) begin
            irq = 1'b1;
            cyc();
            exp_pc = exp_pc + 1;
            check("R3 hold after request", 32'(hold), 1);
            check("R3 busy after request", 32'(busy), 1);
            irq = 1'b0;
        end
        cyc();  // now draining
        check("R3 pc frozen while holding", pc, exp_pc);
        for (int i = 0; i < dl; i++) begin
            rti = rti_in_drain;
            if (br && i == 0) begin
                branch = 1'b1;
                tgt    = 32'h00C0_FFEE;
            end
            cyc();
            if (br && i == 0) exp_pc = 32'h00C0_FFEE;
            branch = 1'b0;
            check("R4 no access before drain", 32'(mreq), 0);
            check("R9 sp untouched by rti", 32'(sp), 32'(exp_sp));
            check("R4 branch in drain updates pc", pc, exp_pc);
        end
        rti     = 1'b0;
        drained = 1'b1;
        cyc();  // push cycle
        check("R5 push request", 32'({mreq, mwe}), 3);
        check("R5 push address", 32'(maddr), 32'(exp_sp - 12'd1));
        check("R5 push data", mwdata, exp_pc);
        shadow[depth] = exp_pc;
        depth++;
        drained = 1'b0;
        cyc();  // vector read cycle
        exp_sp = exp_sp - 12'd2;
        check("R5 sp after push", 32'(sp), 32'(exp_sp));
        check("R6 vector read", {mreq, mwe, 18'd0, maddr}, {2'b10, 18'd0, 12'd2});
        if (extra) irq = 1'b1;
        cyc();  // load cycle
        irq = 1'b0;
        check("R6 busy during load", 32'(busy), 1);
        cyc();
        exp_pc = VEC;
        check("R6 pc from vector", pc, exp_pc);
        check("R6 R8 busy after load", 32'(busy), 32'(extra));
        pc_inc = 1'b0;
    endtask

    task automatic do_rti(input bit extra);
        pc_inc = 1'b0;
        rti    = 1'b1;
        cyc();
        check("R7 pop read", {mreq, mwe, 18'd0, maddr}, {2'b10, 18'd0, exp_sp + 12'd1});
        rti = 1'b0;
        if (extra) irq = 1'b1;
        cyc();
        irq = 1'b0;
        exp_sp = exp_sp + 12'd2;
        check("R7 sp after pop", 32'(sp), 32'(exp_sp));
        cyc();
        depth--;
        exp_pc = shadow[depth];
        check("R7 pc restored", pc, exp_pc);
        if (extra) check("R8 request held during return", 32'(busy), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        check("R1 reset pc", pc, 0);
        check("R1 reset sp", 32'(sp), 32'hFFF);
        check("R1 reset flags", 32'({busy, hold, mreq}), 0);

        run(5);
        pc_inc = 1'b1;
        branch = 1'b1;
        tgt    = 32'h100;
        cyc();
        exp_pc = 32'h100;
        check("R2 branch over increment", pc, exp_pc);
        branch = 1'b0;
        run(3);

        // sweep drain delay and nesting depth
        for (int dl = 0; dl < 3; dl++) begin
            for (int d = 1; d <= 3; d++) begin
                for (int k = 0; k < d; k++) begin
                    enter_irq(dl, 1'b1, 1'b0, dl == 1, (k == 0) && (dl == 2));
                    run(k + 2);
                end
                for (int k = 0; k < d; k++) begin
                    do_rti(1'b0);
                    run(1);
                end
            end
        end

        // R8: request during entry is serviced afterwards
        enter_irq(1, 1'b1, 1'b1, 1'b0, 1'b0);
        enter_irq(0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_rti(1'b0);
        do_rti(1'b0);

        // R8: request during return
        enter_irq(0, 1'b1, 1'b0, 1'b0, 1'b0);
        run(2);
        do_rti(1'b1);
        enter_irq(0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_rti(1'b0);

        // R8: return beats a pending request in the same idle cycle
        enter_irq(0, 1'b1, 1'b0, 1'b0, 1'b0);
        run(1);
        irq = 1'b1;
        cyc();
        irq = 1'b0;
        do_rti(1'b0);
        enter_irq(0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_rti(1'b0);

        // R10: wrap of the stack pointer in both directions
        check("R10 sp back at top", 32'(sp), 32'hFFF);
        shadow[0] = {initv(1), initv(0)};
        depth     = 1;
        do_rti(1'b0);
        check("R10 sp wrapped up", 32'(sp), 32'h001);
        enter_irq(0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 sp wrapped down", 32'(sp), 32'hFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule